// File: doc/BRIEF.md
# Smart Card Clock Generator

This block produces the clock that drives a smart card contact. Two free-running sources feed it: a fast external system clock and a slow internal oscillator (about 1.25 MHz). In normal operation a select bit picks one of them. The external path can be divided by 1, 2 or 4. A power-down bit moves the card into one of three sleep behaviours: the clock parked low, the clock parked high, or the oscillator running at half rate. An enable from the session sequencer gates the whole output. While that enable is low the card clock rests low.

Every change is made at a phase boundary, so the card never sees a truncated pulse. This covers a source swap, a divider change, entering or leaving sleep, and enabling or disabling. Each source has its own gating branch, clocked by that source. The branch takes the control bundle through a synchronizer chain. It only changes its gate or its waveform mode while its own output phase is low. A branch switches on only after it sees the other branch report itself off. Control inputs are expected to stay unchanged for at least five oscillator periods between updates.

Top module: `card_clk_gen`

## Requirements
- R1: During reset, and while `seq_en` is 0, `card_clk` is held at 0 with no edges.
- R2: With `seq_en`=1, `pd`=0, `src_sel`=0 and `div_sel`=00, `card_clk` follows the external clock, with high and low phases each lasting half an external period.
- R3: With the external source selected, `div_sel`=01 divides it by 2, and `div_sel`=10 or 11 divides it by 4. Each phase lasts 1 or 2 external periods respectively.
- R4: With `seq_en`=1, `pd`=0 and `src_sel`=1, `card_clk` follows the oscillator undivided.
- R5: With `pd`=1, `sleep_sel`=00 or 11 parks `card_clk` at 0. While `pd`=0, `sleep_sel` has no effect on the output.
- R6: With `pd`=1 and `sleep_sel`=01, `card_clk` is parked at 1 with no edges.
- R7: With `pd`=1 and `sleep_sel`=10, `card_clk` runs at half the oscillator frequency, with each phase lasting one oscillator period.
- R8: The first high pulse after enabling from rest lasts a full half period of the selected waveform.
- R9: Across any control change, no high or low phase of `card_clk` is shorter than 45% of the external clock period. At no time are both sources gated onto the output.
- R10: In steady running, the high time of `card_clk` is between 45% and 55% of its period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ext | input | 1 | External system clock source |
| clk_osc | input | 1 | Internal oscillator clock source |
| rst_n | input | 1 | Asynchronous active-low reset for both source domains |
| seq_en | input | 1 | Enable from the session sequencer; 0 rests the card clock low |
| src_sel | input | 1 | Normal source: 0 external, 1 oscillator |
| div_sel | input | 2 | External divide: 00 by 1, 01 by 2, 10/11 by 4 |
| pd | input | 1 | Power-down; 1 applies the sleep behaviour |
| sleep_sel | input | 2 | Sleep behaviour: 00/11 low, 01 high, 10 oscillator/2 |
| card_clk | output | 1 | Clock driven to the card |

## Verification
The bench builds the block with `SYNC_STAGES`=3, one stage deeper than the default. This stretches every handover between the two branches and puts the longest settling path under test. The external clock runs at 20 MHz and the oscillator at 1.25 MHz, so the two clocks differ by a factor of sixteen. That ratio makes a short pulse at a swap easy to tell apart from a legitimate half period. It also places the parked-high state behind a cross-domain handshake that has to wait for the external branch to let go.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

    // Waveform produced by one source branch
    typedef enum logic [1:0] {
        PM_RAW  = 2'd0,  // source clock passed straight through
        PM_DIV2 = 2'd1,  // source divided by 2
        PM_DIV4 = 2'd2,  // source divided by 4
        PM_HOLD = 2'd3   // parked high
    } ph_mode_e;

    // Sleep behaviour codes
    localparam logic [1:0] SLP_LOW  = 2'b00;
    localparam logic [1:0] SLP_HIGH = 2'b01;
    localparam logic [1:0] SLP_SLOW = 2'b10;

    // Branch indices
    localparam int BR_EXT = 0;
    localparam int BR_OSC = 1;
    localparam int N_BR   = 2;

    // Control bundle crossing into a branch domain
    typedef struct packed {
        logic     req;   // branch should drive the output
        logic     peer;  // other branch currently gated on
        ph_mode_e want;  // requested waveform
    } br_ctl_t;

    // State updated on the rising source edge
    typedef struct packed {
        logic div;
        logic cnt;
    } br_pos_t;

    // State updated on the falling source edge
    typedef struct packed {
        logic     gate;
        ph_mode_e mode;
    } br_neg_t;

endpackage

// File: rtl/card_clk_sync.sv
module card_clk_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/card_clk_branch.sv
module card_clk_branch
    import card_clk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  br_ctl_t  ctl_a,    // asynchronous to clk
    output logic     on_o,     // gate state, reported to the peer
    output ph_mode_e mode_o,
    output logic     gated_o   // this branch's share of the card clock
);

    localparam int CTL_W = $bits(br_ctl_t);

    br_ctl_t ctl_s;
    br_pos_t pos_d, pos_q;
    br_neg_t neg_d, neg_q;
    logic    ph_low;

    card_clk_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_a),
        .q     (ctl_s)
    );

    always_comb begin
        // rising-edge state: divider and park register
        pos_d = pos_q;
        unique case (neg_q.mode)
            PM_RAW: begin
                pos_d.div = 1'b0;
                pos_d.cnt = 1'b0;
            end
            PM_DIV2: begin
                pos_d.div = ~pos_q.div;
                pos_d.cnt = 1'b0;
            end
            PM_DIV4: begin
                pos_d.cnt = ~pos_q.cnt;
                if (pos_q.cnt) pos_d.div = ~pos_q.div;
            end
            default: begin
                // park high only once gated on; drop when no longer wanted
                pos_d.div = (ctl_s.want == PM_HOLD) && neg_q.gate;
                pos_d.cnt = 1'b0;
            end
        endcase

        // falling edge: in RAW the source just fell, otherwise look at divider
        ph_low = (neg_q.mode == PM_RAW) || !pos_q.div;

        neg_d = neg_q;
        if (ph_low) begin
            neg_d.mode = ctl_s.want;
            neg_d.gate = ctl_s.req && (neg_q.gate || !ctl_s.peer);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q.gate <= 1'b0;
            neg_q.mode <= PM_RAW;
        end else begin
            neg_q <= neg_d;
        end
    end

    assign on_o    = neg_q.gate;
    assign mode_o  = neg_q.mode;
    assign gated_o = neg_q.gate & ((neg_q.mode == PM_RAW) ? clk : pos_q.div);

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
    import card_clk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_ext,
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic       seq_en,
    input  logic       src_sel,
    input  logic [1:0] div_sel,
    input  logic       pd,
    input  logic [1:0] sleep_sel,
    output logic       card_clk
);

    logic [N_BR-1:0] br_clk;
    logic [N_BR-1:0] br_on;
    logic [N_BR-1:0] br_gated;
    ph_mode_e        br_mode [N_BR];
    br_ctl_t         br_ctl  [N_BR];
    logic            sleep_runs;

    assign br_clk[BR_EXT] = clk_ext;
    assign br_clk[BR_OSC] = clk_osc;

    always_comb begin
        sleep_runs = (sleep_sel == SLP_HIGH) || (sleep_sel == SLP_SLOW);

        // external branch: normal mode only
        br_ctl[BR_EXT].req  = seq_en && !pd && !src_sel;
        br_ctl[BR_EXT].peer = br_on[BR_OSC];
        unique case (div_sel)
            2'b00:   br_ctl[BR_EXT].want = PM_RAW;
            2'b01:   br_ctl[BR_EXT].want = PM_DIV2;
            default: br_ctl[BR_EXT].want = PM_DIV4;
        endcase

        // oscillator branch: normal mode or running sleep behaviours
        br_ctl[BR_OSC].req  = seq_en && (pd ? sleep_runs : src_sel);
        br_ctl[BR_OSC].peer = br_on[BR_EXT];
        if (!br_ctl[BR_OSC].req || !pd)      br_ctl[BR_OSC].want = PM_RAW;
        else if (sleep_sel == SLP_HIGH)      br_ctl[BR_OSC].want = PM_HOLD;
        else                                 br_ctl[BR_OSC].want = PM_DIV2;
    end

    for (genvar b = 0; b < N_BR; b++) begin : g_br
        card_clk_branch #(.SYNC_STAGES(SYNC_STAGES)) u_br (
            .clk     (br_clk[b]),
            .rst_n   (rst_n),
            .ctl_a   (br_ctl[b]),
            .on_o    (br_on[b]),
            .mode_o  (br_mode[b]),
            .gated_o (br_gated[b])
        );
    end

    assign card_clk = |br_gated;

endmodule

// File: rtl/card_clk_gen_chk.sv
module card_clk_gen_chk
    import card_clk_pkg::*;
(
    input logic       clk_ext,
    input logic       clk_osc,
    input logic       rst_n,
    input logic       card_clk,
    input logic [1:0] br_on,
    input logic [1:0] osc_mode
);

    // R9: the two sources are never gated on together
    assert_one_source_ext_R9: assert property (@(posedge clk_ext) disable iff (!rst_n)
        !(br_on[0] && br_on[1]));

    assert_one_source_osc_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !(br_on[0] && br_on[1]));

    // R9: a gate only opens or closes while the card clock is low
    assert_ext_gate_low_R9: assert property (@(posedge clk_ext) disable iff (!rst_n)
        !$stable(br_on[0]) |-> !card_clk);

    assert_osc_gate_low_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $rose(br_on[1]) |-> !card_clk);

    // R6: a settled parked state drives the card clock high
    assert_park_high_R6: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (br_on[1] && osc_mode == PM_HOLD && $past(br_on[1]) && $past(osc_mode) == PM_HOLD)
        |-> card_clk);

endmodule

bind card_clk_gen card_clk_gen_chk u_chk (
    .clk_ext  (clk_ext),
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .card_clk (card_clk),
    .br_on    (br_on),
    .osc_mode (br_mode[1])
);

// File: tb/card_clk_gen_tb_top.sv
`timescale 1ns/1ps
module card_clk_gen_tb_top;

    localparam int  EXT_PERIOD = 50;   // 20 MHz
    localparam int  OSC_PERIOD = 800;  // 1.25 MHz
    localparam int  SETTLE     = 8 * OSC_PERIOD;
    localparam int  WINDOW     = 5 * OSC_PERIOD;
    localparam real MIN_PHASE  = 0.45 * EXT_PERIOD;

    localparam int K_RUN   = 0;
    localparam int K_LOW   = 1;
    localparam int K_HIGH  = 2;
    localparam int K_FIRST = 3;

    logic       clk_ext = 1'b0;
    logic       clk_osc = 1'b0;
    logic       rst_n;
    logic       seq_en;
    logic       src_sel;
    logic [1:0] div_sel;
    logic       pd;
    logic [1:0] sleep_sel;
    logic       card_clk;

    card_clk_gen #(.SYNC_STAGES(3)) dut_i (
        .clk_ext   (clk_ext),
        .clk_osc   (clk_osc),
        .rst_n     (rst_n),
        .seq_en    (seq_en),
        .src_sel   (src_sel),
        .div_sel   (div_sel),
        .pd        (pd),
        .sleep_sel (sleep_sel),
        .card_clk  (card_clk)
    );

    always #(EXT_PERIOD/2) clk_ext = ~clk_ext;
    always #(OSC_PERIOD/2) clk_osc = ~clk_osc;

    typedef struct {
        int    kind;
        int    hi;
        int    lo;
        string tag;
    } exp_t;

    exp_t    sb_q[$];
    int      n_checks = 0;
    int      n_fail   = 0;
    int      done_cnt = 0;
    int      edge_cnt = 0;
    int      short_cnt = 0;
    real     min_seen = 1.0e9;
    realtime last_edge;
    bit      have_last = 1'b0;
    bit      finished  = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // phase-width monitor over the whole run (R9)
    initial begin
        forever begin
            @(card_clk);
            if (rst_n === 1'b1) begin
                if (have_last) begin
                    if (($realtime - last_edge) < min_seen) min_seen = $realtime - last_edge;
                    if (($realtime - last_edge) < MIN_PHASE) short_cnt++;
                end
                have_last = 1'b1;
                last_edge = $realtime;
                edge_cnt++;
            end
        end
    end

    // scoreboard monitor: pops expected items and measures the output
    initial begin
        forever begin
            exp_t    it;
            realtime t0, t1, t2;
            int      hi, lo, n0;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            case (it.kind)
                K_RUN: begin
                    @(posedge card_clk); t0 = $realtime;
                    @(negedge card_clk); t1 = $realtime;
                    @(posedge card_clk); t2 = $realtime;
                    hi = int'(t1 - t0);
                    lo = int'(t2 - t1);
                    check(hi == it.hi, it.tag, "high phase ns", hi, it.hi);
                    check(lo == it.lo, it.tag, "low phase ns", lo, it.lo);
                    // R10 duty window
                    check((hi * 100 >= 45 * (hi + lo)) && (hi * 100 <= 55 * (hi + lo)),
                          "R10", "duty percent", (hi * 100) / (hi + lo), 50);
                end
                K_FIRST: begin
                    @(posedge card_clk); t0 = $realtime;
                    @(negedge card_clk); t1 = $realtime;
                    hi = int'(t1 - t0);
                    check(hi == it.hi, it.tag, "first high phase ns", hi, it.hi);
                end
                default: begin
                    n0 = edge_cnt;
                    #(WINDOW);
                    check(edge_cnt == n0, it.tag, "edges in parked window", edge_cnt - n0, 0);
                    check(card_clk === (it.kind == K_HIGH), it.tag, "parked level",
                          int'(card_clk), int'(it.kind == K_HIGH));
                end
            endcase
            done_cnt++;
        end
    end

    task automatic expect_item(input int kind, input int hi, input int lo, input string tag);
        int target;
        exp_t it;
        target = done_cnt + 1;
        it.kind = kind; it.hi = hi; it.lo = lo; it.tag = tag;
        sb_q.push_back(it);
        wait (done_cnt == target);
    endtask

    task automatic settle_expect(input int kind, input int hi, input int lo, input string tag);
        #(SETTLE);
        expect_item(kind, hi, lo, tag);
    endtask

    task automatic first_pulse(input int hi, input string tag);
        int target;
        exp_t it;
        target = done_cnt + 1;
        it.kind = K_FIRST; it.hi = hi; it.lo = 0; it.tag = tag;
        sb_q.push_back(it);
        #1;
        seq_en = 1'b1;
        wait (done_cnt == target);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // driver
    initial begin
        logic [15:0] lfsr;
        rst_n = 1'b0; seq_en = 1'b0; src_sel = 1'b0; div_sel = 2'b00;
        pd = 1'b0; sleep_sel = 2'b00;
        #(3 * OSC_PERIOD + 7);
        check(card_clk === 1'b0, "R1", "card_clk during reset", int'(card_clk), 0);
        rst_n = 1'b1;

        // R1: enable low rests the clock
        settle_expect(K_LOW, 0, 0, "R1");

        // R8: first pulse of /4 from rest, then steady /4 (R3)
        div_sel = 2'b10;
        first_pulse(2 * EXT_PERIOD, "R8");
        settle_expect(K_RUN, 2 * EXT_PERIOD, 2 * EXT_PERIOD, "R3");

        // R2: undivided external
        div_sel = 2'b00;
        settle_expect(K_RUN, EXT_PERIOD / 2, EXT_PERIOD / 2, "R2");

        // R3: /2 and code 11 as /4
        div_sel = 2'b01;
        settle_expect(K_RUN, EXT_PERIOD, EXT_PERIOD, "R3");
        div_sel = 2'b11;
        settle_expect(K_RUN, 2 * EXT_PERIOD, 2 * EXT_PERIOD, "R3");

        // R4: oscillator
        src_sel = 1'b1;
        settle_expect(K_RUN, OSC_PERIOD / 2, OSC_PERIOD / 2, "R4");

        // R5 / R6 / R7: sleep behaviours
        pd = 1'b1; sleep_sel = 2'b00;
        settle_expect(K_LOW, 0, 0, "R5");
        sleep_sel = 2'b01;
        settle_expect(K_HIGH, 0, 0, "R6");
        sleep_sel = 2'b10;
        settle_expect(K_RUN, OSC_PERIOD, OSC_PERIOD, "R7");
        sleep_sel = 2'b11;
        settle_expect(K_LOW, 0, 0, "R5");
        sleep_sel = 2'b01;
        settle_expect(K_HIGH, 0, 0, "R6");

        // leave parked high straight to undivided external
        pd = 1'b0; src_sel = 1'b0; div_sel = 2'b00;
        settle_expect(K_RUN, EXT_PERIOD / 2, EXT_PERIOD / 2, "R2");

        // R5: sleep field ignored while pd is 0
        div_sel = 2'b01;
        #(SETTLE);
        sleep_sel = 2'b01;
        settle_expect(K_RUN, EXT_PERIOD, EXT_PERIOD, "R5");
        sleep_sel = 2'b00;
        settle_expect(K_RUN, EXT_PERIOD, EXT_PERIOD, "R5");

        // R8: first pulse of the oscillator from rest
        seq_en = 1'b0;
        settle_expect(K_LOW, 0, 0, "R1");
        src_sel = 1'b1;
        first_pulse(OSC_PERIOD / 2, "R8");

        // R9: churn the controls, then confirm a clean steady state
        lfsr = 16'hACE1;
        for (int i = 0; i < 25; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            seq_en    = (lfsr[2:0] != 3'd0);
            src_sel   = lfsr[3];
            div_sel   = lfsr[5:4];
            pd        = lfsr[6] & lfsr[7];
            sleep_sel = lfsr[9:8];
            #(5 * OSC_PERIOD + int'(lfsr[9:0]));
        end
        seq_en = 1'b1; pd = 1'b0; src_sel = 1'b0; div_sel = 2'b10;
        settle_expect(K_RUN, 2 * EXT_PERIOD, 2 * EXT_PERIOD, "R3");
        check(short_cnt == 0, "R9", "phases shorter than 45% of external period",
              short_cnt, 0);
        check(min_seen >= MIN_PHASE, "R9", "shortest phase ns", int'(min_seen),
              int'(EXT_PERIOD / 2));

        finished = 1'b1;
        summary();
        $finish;
    end

    // watchdog
    initial begin
        #(4_000_000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run state actual hung expected complete");
            summary();
            $finish;
        end
    end

endmodule